// File: doc/BRIEF.md
# Transfer Credit and Length Counters

This block keeps the two flow-control counters a host polls before moving data to or from a slave device. The first is a 12-bit receive credit: the slave side pulses an input each time it loads an empty receive buffer, and the count goes up by one. The second is a 20-bit running total of bytes the slave has made available for sending. Both counters only grow, and both wrap at their width. The host therefore works out the free buffers, or the unread bytes, by subtracting what it has already used from the value it reads. That subtraction is modulo the counter width. A receive buffer the host fills only partly still counts as one used buffer, and the block never takes credit back.

Send lengths reach the total in one of two ways. In stream mode each accepted length is added at once. In packet mode lengths wait in an 8-entry queue. The head is added only once the read datapath has reported, through its consumed-byte feed, that every byte published so far has been read. The host reads both counters through a byte-addressed read port with zero latency. Any length above 4092 bytes is refused and flagged. An enqueue made while the packet queue is full is dropped, and a busy output warns of this beforehand.

Top module: `xfer_credit_regs`

## Requirements
- R1: A read at byte address 0x044 returns the receive credit in bits 27:16, with every other bit zero.
- R2: Each clock with `buf_load` high raises the credit by one, visible after that edge. The count wraps from 4095 to 0.
- R3: Consumed bytes, send enqueues and host reads never lower or otherwise change the credit.
- R4: A read at byte address 0x060 returns the send total in bits 19:0 with bits 31:20 zero. Any address other than 0x044 and 0x060 reads as zero.
- R5: With `pkt_mode` low, an accepted length is added to the send total at the edge that samples the enqueue, whether or not earlier bytes have been read.
- R6: With `pkt_mode` high, a queued length is held back while the consumed-byte count differs from the send total. It is added one edge after the two become equal.
- R7: Packet-mode lengths are published one at a time, in enqueue order.
- R8: An enqueue with `enq_len` above 4092 changes neither the total nor the queue, and `enq_err` is high for the one cycle after it.
- R9: The packet queue holds 8 lengths. `enq_busy` is high while it is full in packet mode, and an enqueue made then is dropped.
- R10: The send total wraps modulo 2^20.
- R11: After reset both counters are zero, the queue is empty, and `enq_err` and `enq_busy` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_mode | input | 1 | 1 = packet mode, 0 = stream mode |
| buf_load | input | 1 | One receive buffer loaded this cycle |
| enq_valid | input | 1 | Send buffer enqueued this cycle |
| enq_len | input | 13 | Byte length of the enqueued buffer |
| enq_busy | output | 1 | Packet queue full; an enqueue now is dropped |
| enq_err | output | 1 | Previous-cycle enqueue exceeded 4092 bytes |
| rd_valid | input | 1 | Read datapath delivered bytes this cycle |
| rd_bytes | input | 13 | Number of bytes delivered |
| host_addr | input | 17 | Host read byte address |
| host_rdata | output | 32 | Host read data, combinational |

## Verification
Host reads are combinational, so a counter shows its new value right after the edge that updates it. The credit, a stream-mode sum and the error flag are each due one edge after their stimulus. A packet-mode length needs two edges: one to take it into the queue, or to bring the consumed count level with the total, and one to publish it. The bench drives every input on a falling edge and samples on the next falling edge. For packet mode it checks the total both after the first edge, where it must still be unchanged, and after the second. Busy is combinational on the queue count and is sampled in the same half cycle as the enqueue that fills the queue.

// File: rtl/xfer_credit_regs.sv
module xfer_credit_regs #(
  parameter int ADDR_W      = 17,
  parameter int CREDIT_W    = 12,
  parameter int TOTAL_W     = 20,
  parameter int LEN_W       = 13,
  parameter int MAX_LEN     = 4092,
  parameter int DEPTH       = 8,
  parameter int CREDIT_ADDR = 'h044,
  parameter int TOTAL_ADDR  = 'h060,
  parameter int CREDIT_LSB  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_mode,
  input  logic              buf_load,
  input  logic              enq_valid,
  input  logic [LEN_W-1:0]  enq_len,
  output logic              enq_busy,
  output logic              enq_err,
  input  logic              rd_valid,
  input  logic [LEN_W-1:0]  rd_bytes,
  input  logic [ADDR_W-1:0] host_addr,
  output logic [31:0]       host_rdata
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CREDIT_W-1:0] credit;
  logic [TOTAL_W-1:0]  sent_total, consumed;
  logic [LEN_W-1:0]    q [DEPTH];
  logic [PTR_W-1:0]    wr_ptr, rd_ptr;
  logic [CNT_W-1:0]    q_cnt;

  wire len_ok  = enq_len <= LEN_W'(MAX_LEN);
  wire accept  = enq_valid && len_ok;
  wire q_full  = q_cnt == CNT_W'(DEPTH);
  wire direct  = accept && !pkt_mode;
  wire push    = accept && pkt_mode && !q_full;
  wire drained = sent_total == consumed;
  wire pop     = (q_cnt != '0) && drained;

  wire [TOTAL_W-1:0] add_direct = direct ? TOTAL_W'(enq_len) : '0;
  wire [TOTAL_W-1:0] add_pop    = pop ? TOTAL_W'(q[rd_ptr]) : '0;

  assign enq_busy = pkt_mode && q_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      credit     <= '0;
      sent_total <= '0;
      consumed   <= '0;
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      q_cnt      <= '0;
      enq_err    <= 1'b0;
    end else begin
      if (buf_load) credit <= credit + 1'b1;
      if (rd_valid) consumed <= consumed + TOTAL_W'(rd_bytes);
      sent_total <= sent_total + add_direct + add_pop;
      if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      q_cnt   <= q_cnt + CNT_W'(push) - CNT_W'(pop);
      enq_err <= enq_valid && !len_ok;
    end
  end

  always_ff @(posedge clk)
    if (push) q[wr_ptr] <= enq_len;

  always_comb begin
    host_rdata = '0;
    if (host_addr == ADDR_W'(CREDIT_ADDR))
      host_rdata = 32'(credit) << CREDIT_LSB;
    else if (host_addr == ADDR_W'(TOTAL_ADDR))
      host_rdata = 32'(sent_total);
  end

  AST_CREDIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    buf_load |=> credit == $past(credit) + 1'b1); // R2
  AST_CREDIT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_load |=> credit == $past(credit)); // R3
  AST_STREAM_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (direct && !pop) |=> sent_total == $past(sent_total) + TOTAL_W'($past(enq_len))); // R5
  AST_PKT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!drained && !(enq_valid && !pkt_mode)) |=> $stable(sent_total)); // R6
  AST_OVERSIZE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && enq_len > LEN_W'(MAX_LEN)) |=> enq_err); // R8
  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= CNT_W'(DEPTH)); // R9
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_busy && !pop) |=> q_cnt == $past(q_cnt)); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr != ADDR_W'(CREDIT_ADDR) && host_addr != ADDR_W'(TOTAL_ADDR)) |-> host_rdata == '0); // R4
endmodule

// File: tb/test_xfer_credit_regs.sv
module test_xfer_credit_regs;
  logic clk = 0, rst_n = 0, pkt_mode = 0, buf_load = 0, enq_valid = 0, rd_valid = 0;
  logic [12:0] enq_len = '0, rd_bytes = '0;
  logic [16:0] host_addr = '0;
  logic enq_busy, enq_err;
  logic [31:0] host_rdata;
  int total = 0, bad = 0;

  xfer_credit_regs i_xfer_credit_regs (.*);

  always #5 clk = ~clk;

  localparam int NV = 5;
  localparam logic [12:0] VLEN [NV] = '{13'd100, 13'd4092, 13'd0, 13'd1, 13'd2000};
  localparam logic [31:0] VEXP [NV] = '{32'd100, 32'd4192, 32'd4192, 32'd4193, 32'd6193};

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic rd(input logic [16:0] a, output logic [31:0] d);
    host_addr = a; #1; d = host_rdata;
  endtask

  task automatic enq(input logic [12:0] l);
    enq_valid = 1; enq_len = l; tick(); enq_valid = 0;
  endtask

  task automatic consume(input logic [12:0] n);
    rd_valid = 1; rd_bytes = n; tick(); rd_valid = 0;
  endtask

  task automatic load(); buf_load = 1; tick(); buf_load = 0; endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    tick(); tick(); rst_n = 1; tick();
    rd(17'h044, d); check("R11 credit", d, 0);
    rd(17'h060, d); check("R11 total", d, 0);
    check("R11 err", {31'd0, enq_err}, 0);
    check("R11 busy", {31'd0, enq_busy}, 0);

    load(); load(); load();
    rd(17'h044, d); check("R1 R2 credit field", d, 32'd3 << 16);
    for (int i = 0; i < 4093; i++) load();
    rd(17'h044, d); check("R2 credit wrap", d, 0);
    load();
    rd(17'h044, d); check("R2 after wrap", d, 32'd1 << 16);

    for (int i = 0; i < NV; i++) begin
      enq(VLEN[i]);
      rd(17'h060, d); check("R5 stream sum", d, VEXP[i]);
    end

    enq(13'd4093);
    check("R8 err flag", {31'd0, enq_err}, 1);
    rd(17'h060, d); check("R8 total unchanged", d, 6193);
    tick(); check("R8 err clears", {31'd0, enq_err}, 0);

    consume(13'd6193);
    rd(17'h044, d); check("R3 credit not lowered", d, 32'd1 << 16);

    pkt_mode = 1;
    enq(13'd50);
    rd(17'h060, d); check("R6 first edge held", d, 6193);
    tick();
    rd(17'h060, d); check("R6 published", d, 6243);
    enq(13'd70); enq(13'd80); tick();
    rd(17'h060, d); check("R6 held while unread", d, 6243);
    consume(13'd30); tick();
    rd(17'h060, d); check("R6 partial read holds", d, 6243);
    consume(13'd20);
    rd(17'h060, d); check("R6 drained edge", d, 6243);
    tick();
    rd(17'h060, d); check("R7 first in order", d, 6313);
    consume(13'd70); tick();
    rd(17'h060, d); check("R7 second in order", d, 6393);

    for (int i = 0; i < 8; i++) enq(13'd1);
    check("R9 busy when full", {31'd0, enq_busy}, 1);
    enq(13'd5);
    consume(13'd80); tick();
    for (int i = 0; i < 7; i++) begin consume(13'd1); tick(); end
    rd(17'h060, d); check("R9 queue drained", d, 6401);
    check("R9 busy released", {31'd0, enq_busy}, 0);
    consume(13'd1); tick(); tick();
    rd(17'h060, d); check("R9 dropped enqueue", d, 6401);

    enq(13'd5000);
    check("R8 packet err", {31'd0, enq_err}, 1);
    tick(); tick();
    rd(17'h060, d); check("R8 packet not queued", d, 6401);

    pkt_mode = 0;
    for (int i = 0; i < 254; i++) enq(13'd4092);
    rd(17'h060, d); check("R5 long stream", d, 1045769);
    enq(13'd3000);
    rd(17'h060, d); check("R10 total wrap", d, 193);

    rd(17'h048, d); check("R4 unmapped", d, 0);
    rd(17'h000, d); check("R4 unmapped zero addr", d, 0);
    rd(17'h044, d); check("R3 credit final", d, 32'd1 << 16);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule